// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block brings an Ethernet PHY from an unknown state to a configured link without a processor. On a start request it soft-resets the PHY through a register-access port, polls until the reset clears, optionally waits a settling delay, and then either negotiates or forces the link. The register-access port carries one read or write of a 16-bit PHY register at a time. It is meant to sit in front of a serial management master that moves the words on the wire.

In negotiation mode the sequencer advertises every 10 and 100 Mb/s ability, restarts negotiation, and polls the status register once per millisecond tick. It then reads back its own advertisement and the partner's abilities and resolves the best common mode. In forced mode it writes the chosen speed and duplex, flags the link as configured, and reads the control register back to report the mode the PHY actually holds. A one-cycle progress pulse marks each elapsed second-scale interval of a long negotiation wait. Separate reset and negotiation timeouts end a stuck sequence with a status flag.

Top module: `phy_linkup_seq`

## Requirements
- R1: When `start` is accepted, the first access issued is a write of 0x8000 (bit 15, soft reset) to register 0 of the PHY at `phy_addr`.
- R2: After the reset write, register 0 is read, and read again after each `tick_ms`, until bit 15 reads 0. If RST_TIMEOUT_MS ticks have elapsed and bit 15 still reads 1, `err_reset` is set, `busy` drops, and no further access is issued.
- R3: After bit 15 reads 0, no access is issued for POST_RST_DELAY_MS ticks.
- R4: In negotiation mode (`cfg_autoneg`=1) the next writes are 0x01E1 to register 4 and then 0x1200 (bit 12 enable, bit 9 restart) to register 0, in that order.
- R5: In forced mode the only write after the reset is register 0 with bit 13 = `cfg_speed100`, bit 8 = `cfg_full_duplex` and all other bits 0. `configured` is set after that write, and `link_speed100`/`link_full` come from bits 13 and 8 of a read-back of register 0.
- R6: In negotiation mode register 1 is read, and re-read after each tick, until bit 5 reads 1. Only then is `configured` set.
- R7: If ANEG_TIMEOUT_MS ticks elapse without bit 5 set, `err_aneg` is set, `configured` stays 0, and `busy` drops.
- R8: While waiting for negotiation, `progress` pulses for one cycle every PROGRESS_MS ticks, counted from the restart write.
- R9: After negotiation the link mode is resolved from register 4 AND register 5, by priority: bit 8 gives 100 full, bit 7 gives 100 half, bit 6 gives 10 full, and otherwise the mode is 10 half.
- R10: `start` is ignored while `busy` is 1. An accepted `start` clears `configured`, `err_reset`, `err_aneg` and the link outputs.
- R11: Once `mg_req` is raised, `mg_write`, `mg_reg` and `mg_wdata` hold steady until a cycle in which `mg_done` is 1, which ends the access.
- R12: After reset all outputs are 0 and no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| start | input | 1 | Begin a bring-up sequence |
| cfg_autoneg | input | 1 | 1 = negotiate, 0 = forced mode |
| cfg_speed100 | input | 1 | Forced mode: 1 = 100 Mb/s |
| cfg_full_duplex | input | 1 | Forced mode: 1 = full duplex |
| phy_addr | input | 5 | PHY address used for every access |
| mg_req | output | 1 | Access request, held until done |
| mg_write | output | 1 | 1 = write, 0 = read |
| mg_phy | output | 5 | PHY address of the access |
| mg_reg | output | 5 | Register number of the access |
| mg_wdata | output | 16 | Write data |
| mg_done | input | 1 | Access complete (read data valid) |
| mg_rdata | input | 16 | Read data |
| busy | output | 1 | Sequence in progress |
| configured | output | 1 | Link configured |
| err_reset | output | 1 | Reset bit did not clear in time |
| err_aneg | output | 1 | Negotiation did not complete in time |
| link_speed100 | output | 1 | Resolved speed: 1 = 100 Mb/s |
| link_full | output | 1 | Resolved duplex: 1 = full |
| progress | output | 1 | Periodic pulse during negotiation wait |

## Verification
A wrong sequencer state shows up at the access port first. An access that is out of order, missing or extra shows in the logged write list within one access latency. A wrong register number or word shows there as well. A timer that counts wrong shows as a delay of the wrong length between the reset-clear read and the next write, as a wrong number of progress pulses, or as a timeout flag raised too early or not at all, tick-accurate. A resolver fault shows only in `link_speed100` and `link_full`, one cycle after the final read. So the bench drives every priority case of the resolver.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_LPA  = 5'd5;

  localparam int B_RESET  = 15;
  localparam int B_SPD100 = 13;
  localparam int B_ANEN   = 12;
  localparam int B_ANRST  = 9;
  localparam int B_FULL   = 8;
  localparam int B_ANDONE = 5;

  localparam logic [15:0] ADV_10_100_ALL = 16'h01E1;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_WR, S_RST_RD, S_RST_WAIT, S_POST,
    S_ADV_WR, S_CTL_WR, S_STS_RD, S_STS_WAIT,
    S_ADV_RD, S_LPA_RD, S_FRC_RD, S_FINISH
  } seq_state_e;

  typedef struct packed {
    logic        req;
    logic        write;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mgmt_cmd_t;

  localparam mgmt_cmd_t CMD_NONE = '0;

  function automatic mgmt_cmd_t mk_wr(input logic [4:0] r, input logic [15:0] d);
    mgmt_cmd_t c;
    c.req = 1'b1; c.write = 1'b1; c.regad = r; c.wdata = d;
    return c;
  endfunction

  function automatic mgmt_cmd_t mk_rd(input logic [4:0] r);
    mgmt_cmd_t c;
    c.req = 1'b1; c.write = 1'b0; c.regad = r; c.wdata = '0;
    return c;
  endfunction

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/phy_ms_span.sv
module phy_ms_span #(
  parameter int CNT_W = 12,
  parameter bit WRAP  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             hit,
  output logic             wrap_now
);

  logic [CNT_W-1:0] count;

  generate
    if (WRAP) begin : g_wrap
      // periodic divider: wraps at limit-1 and flags the wrapping tick
      assign wrap_now = en && tick && (count == limit - 1'b1);
      assign hit      = 1'b0;

      always_ff @(posedge clk) begin
        if (rst || clr)      count <= '0;
        else if (wrap_now)   count <= '0;
        else if (en && tick) count <= count + 1'b1;
      end

      AST_SPAN_WRAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        en |-> (count < limit)); // R8
    end else begin : g_sat
      // elapsed-tick counter, saturating, compared to a selectable limit
      assign hit      = (count >= limit);
      assign wrap_now = 1'b0;

      always_ff @(posedge clk) begin
        if (rst || clr)                         count <= '0;
        else if (en && tick && (count != '1))   count <= count + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/phy_link_resolve.sv
module phy_link_resolve
  import phy_seq_pkg::*;
(
  input  logic        an_mode,
  input  logic [15:0] ctrl_word,
  input  logic [15:0] adv_word,
  input  logic [15:0] lpa_word,
  output logic        speed100,
  output logic        full_duplex
);

  logic [15:0] common;
  logic        unused_bits;

  assign common = adv_word & lpa_word;
  assign unused_bits = ^{common[15:9], common[5:0],
                         ctrl_word[15:14], ctrl_word[12:9], ctrl_word[7:0]};

  always_comb begin
    if (an_mode) begin
      // priority: 100 full, 100 half, 10 full, else 10 half
      speed100    = common[8] | common[7];
      full_duplex = common[8] | (!common[7] & common[6]);
    end else begin
      speed100    = ctrl_word[B_SPD100];
      full_duplex = ctrl_word[B_FULL];
    end
  end

endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
  import phy_seq_pkg::*;
#(
  parameter int RST_TIMEOUT_MS    = 500,
  parameter int ANEG_TIMEOUT_MS   = 4000,
  parameter int POST_RST_DELAY_MS = 0,
  parameter int PROGRESS_MS       = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_ms,
  input  logic        start,
  input  logic        cfg_autoneg,
  input  logic        cfg_speed100,
  input  logic        cfg_full_duplex,
  input  logic [4:0]  phy_addr,
  output logic        mg_req,
  output logic        mg_write,
  output logic [4:0]  mg_phy,
  output logic [4:0]  mg_reg,
  output logic [15:0] mg_wdata,
  input  logic        mg_done,
  input  logic [15:0] mg_rdata,
  output logic        busy,
  output logic        configured,
  output logic        err_reset,
  output logic        err_aneg,
  output logic        link_speed100,
  output logic        link_full,
  output logic        progress
);

  localparam int MAX_LIM = max_of4(RST_TIMEOUT_MS, ANEG_TIMEOUT_MS,
                                   POST_RST_DELAY_MS, PROGRESS_MS);
  localparam int CNT_W   = $clog2(MAX_LIM + 1) + 1;
  localparam logic [CNT_W-1:0] RST_L  = CNT_W'(RST_TIMEOUT_MS);
  localparam logic [CNT_W-1:0] AN_L   = CNT_W'(ANEG_TIMEOUT_MS);
  localparam logic [CNT_W-1:0] DLY_L  = CNT_W'(POST_RST_DELAY_MS);
  localparam logic [CNT_W-1:0] PROG_L = CNT_W'(PROGRESS_MS);

  localparam logic [15:0] W_RESET = 16'(1) << B_RESET;
  localparam logic [15:0] W_ANRUN = (16'(1) << B_ANEN) | (16'(1) << B_ANRST);

  seq_state_e       state;
  mgmt_cmd_t        cmd_q;
  logic             mode_an, frc_spd, frc_fd;
  logic [15:0]      ctrl_q, adv_q, lpa_q;
  logic [15:0]      frc_word;
  logic             tmr_clr, tmr_hit, prog_en, prog_wrap;
  logic [CNT_W-1:0] tmr_limit;
  logic             res_spd, res_fd;
  logic             unused_tmr_wrap, unused_prog_hit;

  assign mg_req   = cmd_q.req;
  assign mg_write = cmd_q.write;
  assign mg_reg   = cmd_q.regad;
  assign mg_wdata = cmd_q.wdata;

  always_comb begin
    frc_word           = '0;
    frc_word[B_SPD100] = frc_spd;
    frc_word[B_FULL]   = frc_fd;
  end

  // timer control: cleared outside timed phases and on reset-clear
  always_comb begin
    tmr_clr = !(state inside {S_RST_RD, S_RST_WAIT, S_POST, S_STS_RD, S_STS_WAIT})
              || (state == S_RST_RD && mg_done && !mg_rdata[B_RESET]);
    case (state)
      S_POST:               tmr_limit = DLY_L;
      S_STS_RD, S_STS_WAIT: tmr_limit = AN_L;
      default:              tmr_limit = RST_L;
    endcase
    prog_en = state inside {S_STS_RD, S_STS_WAIT};
  end

  phy_ms_span #(.CNT_W(CNT_W), .WRAP(1'b0)) u_phase_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(1'b1), .tick(tick_ms),
    .limit(tmr_limit), .hit(tmr_hit), .wrap_now(unused_tmr_wrap)
  );

  phy_ms_span #(.CNT_W(CNT_W), .WRAP(1'b1)) u_prog_div (
    .clk(clk), .rst(rst), .clr(!prog_en), .en(prog_en), .tick(tick_ms),
    .limit(PROG_L), .hit(unused_prog_hit), .wrap_now(prog_wrap)
  );

  phy_link_resolve u_resolve (
    .an_mode(mode_an), .ctrl_word(ctrl_q), .adv_word(adv_q), .lpa_word(lpa_q),
    .speed100(res_spd), .full_duplex(res_fd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      cmd_q         <= CMD_NONE;
      mg_phy        <= '0;
      busy          <= 1'b0;
      configured    <= 1'b0;
      err_reset     <= 1'b0;
      err_aneg      <= 1'b0;
      link_speed100 <= 1'b0;
      link_full     <= 1'b0;
      progress      <= 1'b0;
      mode_an       <= 1'b0;
      frc_spd       <= 1'b0;
      frc_fd        <= 1'b0;
      ctrl_q        <= '0;
      adv_q         <= '0;
      lpa_q         <= '0;
    end else begin
      progress <= prog_wrap && (state == S_STS_WAIT);
      case (state)
        S_IDLE: if (start) begin
          busy          <= 1'b1;
          configured    <= 1'b0;
          err_reset     <= 1'b0;
          err_aneg      <= 1'b0;
          link_speed100 <= 1'b0;
          link_full     <= 1'b0;
          mode_an       <= cfg_autoneg;
          frc_spd       <= cfg_speed100;
          frc_fd        <= cfg_full_duplex;
          mg_phy        <= phy_addr;
          cmd_q         <= mk_wr(REG_CTRL, W_RESET);
          state         <= S_RST_WR;
        end
        S_RST_WR: if (mg_done) begin
          cmd_q <= mk_rd(REG_CTRL);
          state <= S_RST_RD;
        end
        S_RST_RD: if (mg_done) begin
          cmd_q <= CMD_NONE;
          if (!mg_rdata[B_RESET]) state <= S_POST;
          else if (tmr_hit) begin
            err_reset <= 1'b1;
            busy      <= 1'b0;
            state     <= S_IDLE;
          end else state <= S_RST_WAIT;
        end
        S_RST_WAIT: if (tick_ms) begin
          cmd_q <= mk_rd(REG_CTRL);
          state <= S_RST_RD;
        end
        S_POST: if (tmr_hit) begin
          if (mode_an) begin
            cmd_q <= mk_wr(REG_ADV, ADV_10_100_ALL);
            state <= S_ADV_WR;
          end else begin
            cmd_q <= mk_wr(REG_CTRL, frc_word);
            state <= S_CTL_WR;
          end
        end
        S_ADV_WR: if (mg_done) begin
          cmd_q <= mk_wr(REG_CTRL, W_ANRUN);
          state <= S_CTL_WR;
        end
        S_CTL_WR: if (mg_done) begin
          if (mode_an) begin
            cmd_q <= mk_rd(REG_STAT);
            state <= S_STS_RD;
          end else begin
            configured <= 1'b1;
            cmd_q      <= mk_rd(REG_CTRL);
            state      <= S_FRC_RD;
          end
        end
        S_STS_RD: if (mg_done) begin
          if (mg_rdata[B_ANDONE]) begin
            configured <= 1'b1;
            cmd_q      <= mk_rd(REG_ADV);
            state      <= S_ADV_RD;
          end else if (tmr_hit) begin
            cmd_q    <= CMD_NONE;
            err_aneg <= 1'b1;
            busy     <= 1'b0;
            state    <= S_IDLE;
          end else begin
            cmd_q <= CMD_NONE;
            state <= S_STS_WAIT;
          end
        end
        S_STS_WAIT: if (tick_ms) begin
          cmd_q <= mk_rd(REG_STAT);
          state <= S_STS_RD;
        end
        S_ADV_RD: if (mg_done) begin
          adv_q <= mg_rdata;
          cmd_q <= mk_rd(REG_LPA);
          state <= S_LPA_RD;
        end
        S_LPA_RD: if (mg_done) begin
          lpa_q <= mg_rdata;
          cmd_q <= CMD_NONE;
          state <= S_FINISH;
        end
        S_FRC_RD: if (mg_done) begin
          ctrl_q <= mg_rdata;
          cmd_q  <= CMD_NONE;
          state  <= S_FINISH;
        end
        S_FINISH: begin
          link_speed100 <= res_spd;
          link_full     <= res_fd;
          busy          <= 1'b0;
          state         <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RST_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mg_req && mg_write && mg_reg == REG_CTRL && mg_wdata == W_RESET)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mg_req && !mg_done) |=> (mg_req && $stable(mg_write) && $stable(mg_reg) && $stable(mg_wdata))); // R11
  AST_ADV_WORD: assert property (@(posedge clk) disable iff (rst)
    (mg_req && mg_write && mg_reg == REG_ADV) |-> (mg_wdata == ADV_10_100_ALL)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mg_req); // R10
  AST_CFG_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(configured && (err_reset || err_aneg))); // R7
  AST_END_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (configured || err_reset || err_aneg)); // R6
  AST_PROG_WAIT: assert property (@(posedge clk) disable iff (rst)
    progress |-> (busy && !configured && !err_aneg)); // R8

endmodule

// File: tb/phy_linkup_seq_tb_top.sv
module phy_linkup_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 8;
  localparam int LAT        = 3;
  localparam int RST_TO     = 5;
  localparam int AN_TO      = 35;
  localparam int DLY        = 3;
  localparam int PROG       = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms;
  logic start = 1'b0;
  logic cfg_autoneg = 1'b1, cfg_speed100 = 1'b1, cfg_full_duplex = 1'b1;
  logic [4:0] phy_addr = 5'd7;
  logic mg_req, mg_write, mg_done;
  logic [4:0] mg_phy, mg_reg;
  logic [15:0] mg_wdata, mg_rdata;
  logic busy, configured, err_reset, err_aneg, link_speed100, link_full, progress;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_linkup_seq #(
    .RST_TIMEOUT_MS(RST_TO), .ANEG_TIMEOUT_MS(AN_TO),
    .POST_RST_DELAY_MS(DLY), .PROGRESS_MS(PROG)
  ) dut_i (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .start(start),
    .cfg_autoneg(cfg_autoneg), .cfg_speed100(cfg_speed100),
    .cfg_full_duplex(cfg_full_duplex), .phy_addr(phy_addr),
    .mg_req(mg_req), .mg_write(mg_write), .mg_phy(mg_phy), .mg_reg(mg_reg),
    .mg_wdata(mg_wdata), .mg_done(mg_done), .mg_rdata(mg_rdata),
    .busy(busy), .configured(configured), .err_reset(err_reset),
    .err_aneg(err_aneg), .link_speed100(link_speed100), .link_full(link_full),
    .progress(progress)
  );

  // millisecond tick source
  int tick_div = 0;
  int tick_num = 0;
  always @(posedge clk) begin
    if (rst) begin
      tick_div <= 0; tick_ms <= 1'b0;
    end else begin
      tick_div <= (tick_div == TICK_GAP-1) ? 0 : tick_div + 1;
      tick_ms  <= (tick_div == TICK_GAP-1);
      if (tick_ms) tick_num <= tick_num + 1;
    end
  end

  // PHY register model with access log
  int cfg_rst_reads = 0, cfg_an_reads = 0;
  logic cfg_an_stuck = 1'b0;
  logic [15:0] cfg_lpa = 16'h0;
  logic log_clr = 1'b0;
  logic m_act = 1'b0, m_wr = 1'b0;
  int m_cnt = 0;
  logic [4:0] m_reg = '0;
  logic [15:0] m_wd = '0;
  logic [15:0] r0 = '0, r4 = '0;
  int rst_left = 0, an_left = 0;
  int wr_n = 0, rd0_n = 0, st_n = 0, prog_n = 0, proto_err = 0, bad_phy = 0;
  int clear_tick = 0;
  logic [4:0]  wr_reg_log [16];
  logic [15:0] wr_dat_log [16];
  int          wr_tick_log [16];

  always @(posedge clk) begin
    if (rst) begin
      mg_done <= 1'b0; mg_rdata <= '0; m_act <= 1'b0;
    end else begin
      if (progress) prog_n <= prog_n + 1;
      mg_done <= 1'b0;
      if (log_clr) begin
        wr_n <= 0; rd0_n <= 0; st_n <= 0; prog_n <= 0;
      end else if (!m_act && mg_req && !mg_done) begin
        m_act <= 1'b1; m_cnt <= 0;
        m_reg <= mg_reg; m_wr <= mg_write; m_wd <= mg_wdata;
        if (mg_phy != phy_addr) bad_phy <= bad_phy + 1;
      end else if (m_act) begin
        if (mg_req !== 1'b1 || mg_reg != m_reg || mg_write != m_wr || mg_wdata != m_wd)
          proto_err <= proto_err + 1;
        if (m_cnt == LAT-1) begin
          m_act <= 1'b0; mg_done <= 1'b1;
          if (m_wr) begin
            if (wr_n < 16) begin
              wr_reg_log[wr_n] <= m_reg; wr_dat_log[wr_n] <= m_wd; wr_tick_log[wr_n] <= tick_num;
            end
            wr_n <= wr_n + 1;
            if (m_reg == 5'd0) begin
              if (m_wd[15]) begin r0 <= 16'h0; rst_left <= cfg_rst_reads; end
              else begin r0 <= m_wd; if (m_wd[9]) an_left <= cfg_an_reads; end
            end else if (m_reg == 5'd4) r4 <= m_wd;
          end else begin
            case (m_reg)
              5'd0: begin
                rd0_n <= rd0_n + 1;
                if (rst_left > 0) begin mg_rdata <= r0 | 16'h8000; rst_left <= rst_left - 1; end
                else begin mg_rdata <= r0; clear_tick <= tick_num; end
              end
              5'd1: begin
                st_n <= st_n + 1;
                if (cfg_an_stuck || an_left > 0) begin
                  mg_rdata <= 16'h7809;
                  if (an_left > 0) an_left <= an_left - 1;
                end else mg_rdata <= 16'h782D;
              end
              5'd4: mg_rdata <= r4;
              5'd5: mg_rdata <= cfg_lpa;
              default: mg_rdata <= 16'h0;
            endcase
          end
        end else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic run_seq(input logic an, input logic spd, input logic fd,
                         input int rreads, input int areads, input logic stuck,
                         input logic [15:0] lpa, input logic mid_start);
    @(negedge clk);
    cfg_autoneg = an; cfg_speed100 = spd; cfg_full_duplex = fd;
    cfg_rst_reads = rreads; cfg_an_reads = areads; cfg_an_stuck = stuck; cfg_lpa = lpa;
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1; cfg_autoneg = ~an;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R12 outputs after reset",
          {busy, configured, err_reset, err_aneg, link_speed100, link_full, progress, mg_req}, 0);
  endtask

  task automatic t_aneg_ok();
    run_seq(1'b1, 1'b0, 1'b0, 2, 3, 1'b0, 16'h01E1, 1'b0);
    check("R1 first write reg", wr_reg_log[0], 0);
    check("R1 first write word", wr_dat_log[0], 16'h8000);
    check("R2 reg0 polls until clear", rd0_n, 3);
    check("R3 delay before next write", (wr_tick_log[1] - clear_tick) >= DLY, 1);
    check("R4 adv write reg", wr_reg_log[1], 4);
    check("R4 adv write word", wr_dat_log[1], 16'h01E1);
    check("R4 restart write reg", wr_reg_log[2], 0);
    check("R4 restart write word", wr_dat_log[2], 16'h1200);
    check("R4 write count", wr_n, 3);
    check("R6 status polls", st_n, 4);
    check("R6 configured", configured, 1);
    check("R6 no error", err_reset | err_aneg, 0);
    check("R9 100 full", {link_speed100, link_full}, 2'b11);
  endtask

  task automatic t_resolve();
    logic [15:0] vals [7] = '{16'h0000, 16'h0021, 16'h0041, 16'h0081, 16'h00C1, 16'h0141, 16'h0061};
    for (int k = 0; k < 7; k++) begin
      logic [15:0] c;
      logic es, ef;
      c  = vals[k] & 16'h01E1;
      es = c[8] | c[7];
      ef = c[8] | (!c[7] & c[6]);
      run_seq(1'b1, 1'b0, 1'b0, 0, 1, 1'b0, vals[k], 1'b0);
      check($sformatf("R9 resolve lpa=%h", vals[k]), {link_speed100, link_full}, {es, ef});
    end
  endtask

  task automatic t_forced();
    for (int k = 0; k < 4; k++) begin
      logic s, f;
      s = k[1]; f = k[0];
      run_seq(1'b0, s, f, 1, 0, 1'b0, 16'h0, 1'b0);
      check("R5 forced write count", wr_n, 2);
      check("R5 forced write reg", wr_reg_log[1], 0);
      check("R5 forced word", wr_dat_log[1], (int'(s) << 13) | (int'(f) << 8));
      check("R5 forced configured", configured, 1);
      check("R5 forced link mode", {link_speed100, link_full}, {s, f});
      check("R5 no status polls", st_n, 0);
    end
  endtask

  task automatic t_rst_timeout();
    run_seq(1'b1, 1'b0, 1'b0, 1000, 0, 1'b0, 16'h0, 1'b0);
    check("R2 err_reset", err_reset, 1);
    check("R2 not configured", configured, 0);
    check("R2 no write after reset", wr_n, 1);
    check("R2 poll count in window", (rd0_n >= RST_TO) && (rd0_n <= RST_TO + 2), 1);
  endtask

  task automatic t_aneg_timeout();
    run_seq(1'b1, 1'b0, 1'b0, 0, 0, 1'b1, 16'h01E1, 1'b0);
    check("R7 err_aneg", err_aneg, 1);
    check("R7 not configured", configured, 0);
    check("R7 polls span timeout", st_n > AN_TO - 2, 1);
    check("R8 progress pulses", prog_n, AN_TO / PROG);
  endtask

  task automatic t_restart();
    run_seq(1'b1, 1'b0, 1'b0, 0, 2, 1'b0, 16'h0081, 1'b0);
    check("R10 error flag cleared by start", err_aneg, 0);
    check("R10 configured after restart", configured, 1);
    check("R10 link mode after restart", {link_speed100, link_full}, 2'b10);
  endtask

  task automatic t_start_busy();
    run_seq(1'b1, 1'b0, 1'b0, 1, 4, 1'b0, 16'h0041, 1'b0 | 1'b1);
    check("R10 single sequence writes", wr_n, 3);
    check("R10 configured", configured, 1);
    check("R10 mode from first start", {link_speed100, link_full}, 2'b01);
    repeat (5) @(negedge clk);
    check("R10 stays idle", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_aneg_ok();
    t_resolve();
    t_forced();
    t_rst_timeout();
    t_aneg_timeout();
    t_restart();
    t_start_busy();
    check("R11 handshake held", proto_err, 0);
    check("R1 address on every access", bad_phy, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule